// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a twelve-key keypad wired as four rows by three columns. It pulls one row line low at a time and waits a fixed settle interval. It then looks at the column lines, which are pulled high and read low when a key on the driven row is closed. When a closed key turns up, the scan stops on that row. The block waits for a debounce interval that is set from outside. If the same column is still low at the end of that interval, it issues the key number together with a single-cycle valid pulse.

Each press gives one report. After a report the block stays on the row of that key. It returns to scanning only once no column on that row has read low for an unbroken debounce interval. A key held for a long time is therefore reported once, and a short bounce while the key is let go cannot produce a second report. Every column input passes through a two-stage synchronizer before any decision uses it.

Top module: `kpadScanner`

## Requirements
- R1: While reset is held and right after it, keyValid is 0, keyCode is 0 and rowN is 4'b1110, which means row 0 (bit 0) is driven low.
- R2: At any time after reset, exactly one bit of rowN is 0.
- R3: When no key is pressed, the driven row steps through 0, 1, 2, 3 and back to 0. Each row stays driven for SETTLE_CYCLES clocks (4 by default).
- R4: A key at row r (0..3, matching rowN bit r) and column c (0..2, matching colN bit c) is reported with keyCode = 3*r + c + 1. This is the same value as col + 3*row - 3 when rows and columns are counted from 1, so codes run from 1 to 12.
- R5: A closure that opens again before its debounce interval has ended produces no report.
- R6: A key held for several debounce intervals produces exactly one valid pulse.
- R7: Once a key has been reported, its row must show no low column for a full debounce interval before another key is accepted. A release shorter than that, followed by a new press, is not reported.
- R8: keyValid is high for exactly one clock at a time. keyCode carries the reported value in that cycle and keeps it until the next report.
- R9: No report comes sooner than debounceCount clocks after the key closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colN | input | 3 | Column inputs, active low, pulled high, not synchronized |
| debounceCount | input | 16 | Debounce interval in clocks, used for both press and release |
| rowN | output | 4 | Row drive lines, active low, exactly one low at a time |
| keyCode | output | 4 | Key number from 1 to 12 |
| keyValid | output | 1 | One-clock pulse that marks a new report |

## Verification
Two events can land on the same clock edge. The first case is when the debounce timer expires just as the key being confirmed opens. The bench provokes it with closures shorter than the debounce interval, and it passes only if no valid pulse appears. The second case is when the release timer is still running and the same row reads low again. The bench provokes it with a short release followed by a re-press, and judges that the re-press restarts the release wait and produces no second report. The bench also checks that a key pressed after a full release is still reported.

// File: rtl/kpadPkg.sv
package kpadPkg;

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_RELEASE = 2'd2
  } kpadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rowNext;   // advance to the next row
    logic rowHome;   // return to row 0
    logic tmrClear;  // restart the shared timer
    logic capture;   // record current row and first low column
    logic emit;      // publish key code and pulse valid
  } kpadCtl_t;

endpackage

// File: rtl/kpadDatapath.sv
module kpadDatapath
  import kpadPkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int NUM_COLS      = 3,
  parameter int SETTLE_CYCLES = 4,
  parameter int DEBOUNCE_W    = 16,
  parameter int CODE_W        = $clog2(NUM_ROWS * NUM_COLS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_COLS-1:0]   colN,
  input  logic [DEBOUNCE_W-1:0] debounceCount,
  input  kpadCtl_t              ctl,
  output logic                  tmrSettle,
  output logic                  tmrDone,
  output logic                  anyLow,
  output logic                  keyLow,
  output logic [NUM_ROWS-1:0]   rowN,
  output logic [CODE_W-1:0]     keyCode,
  output logic                  keyValid
);

  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
  localparam logic [DEBOUNCE_W-1:0] SETTLE_END = DEBOUNCE_W'(SETTLE_CYCLES - 1);

  logic [NUM_COLS-1:0]   colMeta, colSync;
  logic [ROW_W-1:0]      rowIdx, keyRow;
  logic [COL_W-1:0]      keyCol, firstCol;
  logic [DEBOUNCE_W-1:0] tmr;
  logic [CODE_W-1:0]     codeCalc;

  // two-stage column synchronizer, idle value is all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colMeta <= '1;
      colSync <= '1;
    end else begin
      colMeta <= colN;
      colSync <= colMeta;
    end
  end

  // row pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx <= '0;
    end else if (ctl.rowHome) begin
      rowIdx <= '0;
    end else if (ctl.rowNext) begin
      rowIdx <= (rowIdx == LAST_ROW) ? '0 : rowIdx + 1'b1;
    end
  end

  always_comb begin
    rowN = '1;
    rowN[rowIdx] = 1'b0;
  end

  // shared settle / debounce / release timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (ctl.tmrClear) begin
      tmr <= '0;
    end else if (tmr != '1) begin
      tmr <= tmr + 1'b1;
    end
  end

  assign tmrSettle = (tmr == SETTLE_END);
  assign tmrDone   = (tmr >= debounceCount);

  // lowest-numbered low column wins
  always_comb begin
    firstCol = '0;
    for (int c = NUM_COLS - 1; c >= 0; c--) begin
      if (!colSync[c]) firstCol = COL_W'(c);
    end
  end

  assign anyLow = ~&colSync;
  assign keyLow = ~colSync[keyCol];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyRow <= '0;
      keyCol <= '0;
    end else if (ctl.capture) begin
      keyRow <= rowIdx;
      keyCol <= firstCol;
    end
  end

  // 1-based: col + NUM_COLS*row - NUM_COLS, same as 0-based col + NUM_COLS*row + 1
  assign codeCalc = CODE_W'(keyCol) + CODE_W'(NUM_COLS) * CODE_W'(keyRow) + CODE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyCode  <= '0;
      keyValid <= 1'b0;
    end else begin
      keyValid <= ctl.emit;
      if (ctl.emit) keyCode <= codeCalc;
    end
  end

  // R2
  rowOneLow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~rowN) == 1);

  // R8
  validPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid);

  // R8
  codeStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emit |=> $stable(keyCode));

  // R4
  codeRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> (int'(keyCode) >= 1 && int'(keyCode) <= NUM_ROWS * NUM_COLS));

endmodule

// File: rtl/kpadControl.sv
module kpadControl
  import kpadPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tmrSettle,
  input  logic     tmrDone,
  input  logic     anyLow,
  input  logic     keyLow,
  output kpadCtl_t ctl
);

  kpadState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_SCAN: begin
        if (tmrSettle) begin
          ctl.tmrClear = 1'b1;
          if (anyLow) begin
            ctl.capture = 1'b1;
            stateNxt    = ST_CONFIRM;
          end else begin
            ctl.rowNext = 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (tmrDone) begin
          ctl.tmrClear = 1'b1;
          if (keyLow) begin
            ctl.emit = 1'b1;
            stateNxt = ST_RELEASE;
          end else begin
            ctl.rowHome = 1'b1;
            stateNxt    = ST_SCAN;
          end
        end
      end
      ST_RELEASE: begin
        if (anyLow) begin
          ctl.tmrClear = 1'b1;
        end else if (tmrDone) begin
          ctl.tmrClear = 1'b1;
          ctl.rowHome  = 1'b1;
          stateNxt     = ST_SCAN;
        end
      end
      default: stateNxt = ST_SCAN;
    endcase
  end

  // R6
  singleEmit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |=> (state == ST_RELEASE));

  // R7
  releaseHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE && anyLow) |=> (state == ST_RELEASE));

endmodule

// File: rtl/kpadScanner.sv
module kpadScanner
  import kpadPkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int NUM_COLS      = 3,
  parameter int SETTLE_CYCLES = 4,
  parameter int DEBOUNCE_W    = 16,
  parameter int CODE_W        = $clog2(NUM_ROWS * NUM_COLS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_COLS-1:0]   colN,
  input  logic [DEBOUNCE_W-1:0] debounceCount,
  output logic [NUM_ROWS-1:0]   rowN,
  output logic [CODE_W-1:0]     keyCode,
  output logic                  keyValid
);

  kpadCtl_t ctl;
  logic tmrSettle, tmrDone, anyLow, keyLow;

  kpadControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tmrSettle(tmrSettle),
    .tmrDone  (tmrDone),
    .anyLow   (anyLow),
    .keyLow   (keyLow),
    .ctl      (ctl)
  );

  kpadDatapath #(
    .NUM_ROWS     (NUM_ROWS),
    .NUM_COLS     (NUM_COLS),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .DEBOUNCE_W   (DEBOUNCE_W),
    .CODE_W       (CODE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .colN         (colN),
    .debounceCount(debounceCount),
    .ctl          (ctl),
    .tmrSettle    (tmrSettle),
    .tmrDone      (tmrDone),
    .anyLow       (anyLow),
    .keyLow       (keyLow),
    .rowN         (rowN),
    .keyCode      (keyCode),
    .keyValid     (keyValid)
  );

endmodule

// File: tb/kpadScanner_tb_top.sv
module kpadScanner_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  colN;
  logic [15:0] debounceCount = 16'd20;
  logic [3:0]  rowN;
  logic [3:0]  keyCode;
  logic        keyValid;

  int checks = 0;
  int errors = 0;

  logic pressed = 1'b0;
  int   pRow = 0;
  int   pCol = 0;

  always #2 clk = ~clk;

  kpadScanner dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .colN         (colN),
    .debounceCount(debounceCount),
    .rowN         (rowN),
    .keyCode      (keyCode),
    .keyValid     (keyValid)
  );

  // keypad model: a pressed key joins its row line to its column line
  always_comb begin
    colN = '1;
    for (int c = 0; c < 3; c++) begin
      if (pressed && pCol == c && rowN[pRow] == 1'b0) colN[c] = 1'b0;
    end
  end

  // {row[1:0], col[1:0], code[3:0]}
  localparam logic [7:0] KEY_VEC [12] = '{
    {2'd0, 2'd0, 4'd1},  {2'd0, 2'd1, 4'd2},  {2'd0, 2'd2, 4'd3},
    {2'd1, 2'd0, 4'd4},  {2'd1, 2'd1, 4'd5},  {2'd1, 2'd2, 4'd6},
    {2'd2, 2'd0, 4'd7},  {2'd2, 2'd1, 4'd8},  {2'd2, 2'd2, 4'd9},
    {2'd3, 2'd0, 4'd10}, {2'd3, 2'd1, 4'd11}, {2'd3, 2'd2, 4'd12}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid(input int maxCyc, output bit found, output int code, output int cyc);
    found = 1'b0;
    code  = 0;
    cyc   = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      cyc++;
      if (keyValid) begin
        found = 1'b1;
        code  = int'(keyCode);
        break;
      end
    end
  endtask

  task automatic countValid(input int nCyc, output int n);
    n = 0;
    for (int i = 0; i < nCyc; i++) begin
      @(negedge clk);
      if (keyValid) n++;
    end
  endtask

  function automatic int lowRow(input logic [3:0] r);
    lowRow = -1;
    for (int i = 0; i < 4; i++) if (r[i] == 1'b0) lowRow = i;
  endfunction

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  initial begin
    bit found;
    int code, cyc, n, prev, dwell, lastCode;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(keyValid == 1'b0, "R1 valid in reset", int'(keyValid), 0);
    check(keyCode == 4'd0, "R1 code in reset", int'(keyCode), 0);
    check(rowN == 4'b1110, "R1 rows in reset", int'(rowN), 14);
    rstN = 1'b1;
    @(negedge clk);
    check(rowN == 4'b1110 && !keyValid, "R1 rows after reset", int'(rowN), 14);

    // R3: idle scan order and dwell time; R2 single low row
    prev = lowRow(rowN);
    dwell = 1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check($countones(~rowN) == 1, "R2 one row low", int'(rowN), 0);
      if (lowRow(rowN) != prev) begin
        check(lowRow(rowN) == (prev + 1) % 4, "R3 row order", lowRow(rowN), (prev + 1) % 4);
        if (n > 0) check(dwell == 4, "R3 row dwell", dwell, 4);
        n++;
        prev = lowRow(rowN);
        dwell = 1;
      end else begin
        dwell++;
      end
    end

    // R4, R6, R8: every key from the vector table
    lastCode = 0;
    foreach (KEY_VEC[k]) begin
      pRow = int'(KEY_VEC[k][7:6]);
      pCol = int'(KEY_VEC[k][5:4]);
      pressed = 1'b1;
      waitValid(100, found, code, cyc);
      check(found && code == int'(KEY_VEC[k][3:0]), "R4 key code", code, int'(KEY_VEC[k][3:0]));
      @(negedge clk);
      check(!keyValid, "R8 valid one cycle", int'(keyValid), 0);
      check(int'(keyCode) == int'(KEY_VEC[k][3:0]), "R8 code held", int'(keyCode), int'(KEY_VEC[k][3:0]));
      countValid(100, n);
      check(n == 0, "R6 single report while held", n, 0);
      pressed = 1'b0;
      countValid(60, n);
      check(n == 0, "R6 no report on release", n, 0);
      lastCode = int'(KEY_VEC[k][3:0]);
    end
    check(int'(keyCode) == lastCode, "R8 code kept after release", int'(keyCode), lastCode);

    // R9: report latency follows debounceCount
    debounceCount = 16'd60;
    pRow = 2; pCol = 1;
    pressed = 1'b1;
    waitValid(200, found, code, cyc);
    check(found && code == 8, "R9 code with long debounce", code, 8);
    check(cyc >= 60, "R9 latency not below debounce", cyc, 60);
    pressed = 1'b0;
    repeat (120) @(negedge clk);

    // R5: closure shorter than the debounce interval
    pRow = 1; pCol = 2;
    pressed = 1'b1;
    repeat (30) @(negedge clk);
    pressed = 1'b0;
    countValid(200, n);
    check(n == 0, "R5 short closure ignored", n, 0);
    pRow = 3; pCol = 0;
    pressed = 1'b1;
    repeat (20) @(negedge clk);
    pressed = 1'b0;
    countValid(200, n);
    check(n == 0, "R5 short closure ignored second", n, 0);

    // R7: short release then re-press must not report again
    pRow = 0; pCol = 2;
    pressed = 1'b1;
    waitValid(200, found, code, cyc);
    check(found && code == 3, "R7 first press reported", code, 3);
    repeat (40) @(negedge clk);
    pressed = 1'b0;
    repeat (25) @(negedge clk);
    pCol = 1;
    pressed = 1'b1;
    countValid(300, n);
    check(n == 0, "R7 re-press within release window ignored", n, 0);
    pressed = 1'b0;
    repeat (120) @(negedge clk);
    pRow = 3; pCol = 2;
    pressed = 1'b1;
    waitValid(200, found, code, cyc);
    check(found && code == 12, "R7 key after full release accepted", code, 12);
    pressed = 1'b0;
    repeat (100) @(negedge clk);
    check($countones(~rowN) == 1, "R2 one row low at end", int'(rowN), 0);

    summary();
  end

endmodule